// File: doc/BRIEF.md
# Floating-Point Exception Flag Resolver

This block sits beside a floating-point execution unit and turns the raw exception conditions of one completed operation into control decisions. Each operation presents five raw conditions (invalid operation, divide-by-zero, overflow, underflow, inexact), five mask bits, a destination-is-memory flag and a round-up indication, qualified by an operation-valid strobe. The block resolves them under a fixed precedence. It updates five sticky status flags and a condition bit (C1). It raises a trap request with a one-hot cause, and it emits a two-bit code that tells the datapath which result to write.

Inexact reporting depends on the overflow/underflow outcome and on the destination. An unmasked overflow or underflow bound for memory hides the inexact condition, clears C1 and suppresses the store. A higher-ranked condition hides every condition ranked below it. The rounding datapath, NaN generation and the trap handler are outside the block.

Top module: `fpx_resolver`

## Requirements
- R1: After reset the sticky flags, C1, the trap request, the trap cause and the result select are all zero.
- R2: Bit positions in the condition, mask, flag and cause vectors are 0 = invalid, 1 = divide-by-zero, 2 = overflow, 3 = underflow, 4 = inexact; a mask bit of 1 masks that condition. Inexact alone and masked sets flag bit 4, selects code 0 (rounded result) and requests no trap.
- R3: Inexact alone and unmasked sets flag bit 4, still selects code 0 (for a register or a memory destination), requests a trap and reports cause bit 4.
- R4: Inexact with masked overflow or underflow sets the overflow/underflow flag together with flag bit 4 and selects code 1 (overflow/underflow default); a trap is requested exactly when inexact is unmasked.
- R5: Inexact with unmasked overflow or underflow and a register destination sets the overflow/underflow flag and flag bit 4, selects code 1 and requests a trap with the overflow/underflow cause.
- R6: Unmasked overflow or underflow with a memory destination leaves flag bit 4 unchanged, clears C1 and selects code 3 (no store).
- R7: Invalid outranks every other condition: when present, all other conditions are ignored (no flags, no cause), flag bit 0 is set, and the select is code 2 (quiet NaN) unless R13 applies.
- R8: Divide-by-zero outranks overflow, underflow and inexact, which are then ignored; it sets flag bit 1 and selects code 1.
- R9: The trap cause is one-hot and names the highest-ranked unmasked condition that was reported; the trap request is high exactly when the cause is non-zero.
- R10: Flags are sticky until the clear input is pulsed; a clear in the same cycle as an operation leaves the flags and C1 at zero.
- R11: With the operation strobe low and no clear, no output changes.
- R12: When inexact is reported, C1 takes the round-up input; otherwise C1 is unchanged, except as R6 and R10 state.
- R13: A memory destination with an unmasked invalid, divide-by-zero, overflow or underflow that is reported selects code 3; an unmasked inexact alone does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation completed this cycle |
| clearFlags | input | 1 | Clears sticky flags and C1 |
| condIn | input | 5 | Raw exception conditions |
| maskIn | input | 5 | Exception masks, 1 = masked |
| destIsMem | input | 1 | Destination is a memory location |
| roundUp | input | 1 | Rounding incremented the magnitude |
| stickyFlags | output | 5 | Sticky status flags |
| c1Bit | output | 1 | Condition bit C1 |
| trapReq | output | 1 | Software trap requested |
| trapCause | output | 5 | One-hot cause of the trap |
| resultSel | output | 2 | 0 rounded, 1 over/underflow default, 2 quiet NaN, 3 no store |

## Verification
Every cycle, the assertions check the following: flags only accumulate between clears, a clear always wins, idle cycles leave every output frozen, and the cause stays one-hot and agrees with the trap request. They also check that an invalid condition never lets a lower flag through and that the memory-overflow case always suppresses inexact and the store. The exact flag, cause and select values for each combination of conditions, masks and destination come only from the bench scenarios. The same holds for C1 first being set and then cleared, and for accumulation across operations.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_COUNT = 5;
  localparam int SEL_WIDTH = 2;

  localparam int BIT_INVALID  = 0;
  localparam int BIT_DIVZERO  = 1;
  localparam int BIT_OVERFLOW = 2;
  localparam int BIT_UNDERFL  = 3;
  localparam int BIT_INEXACT  = 4;

  typedef enum logic [SEL_WIDTH-1:0] {
    SEL_ROUNDED = 2'd0,
    SEL_DEFAULT = 2'd1,
    SEL_QNAN    = 2'd2,
    SEL_NOSTORE = 2'd3
  } resultSel_e;

  typedef struct packed {
    logic [EXC_COUNT-1:0] setFlags;
    logic                 c1Clear;
    logic                 c1Load;
    logic                 c1Value;
    logic                 trapReq;
    logic [EXC_COUNT-1:0] trapCause;
    resultSel_e           resultSel;
  } fpxStrobe_t;
endpackage

// File: rtl/fpx_control.sv
module fpx_control
  import fpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic [EXC_COUNT-1:0] condIn,
  input  logic [EXC_COUNT-1:0] maskIn,
  input  logic                 destIsMem,
  input  logic                 roundUp,
  output fpxStrobe_t           strobe
);
  logic [EXC_COUNT-1:0] unmasked;
  logic [EXC_COUNT-1:0] reported;
  logic [EXC_COUNT-1:0] trapSet;
  logic                 majorUnmasked;
  logic                 ovunTrap;
  logic                 hideInexact;

  assign unmasked = ~maskIn;

  always_comb begin
    reported      = '0;
    majorUnmasked = 1'b0;
    ovunTrap      = 1'b0;
    hideInexact   = 1'b0;
    strobe        = '0;
    strobe.resultSel = SEL_ROUNDED;
    if (condIn[BIT_INVALID]) begin
      reported[BIT_INVALID] = 1'b1;
      majorUnmasked    = unmasked[BIT_INVALID];
      strobe.resultSel = SEL_QNAN;
    end else if (condIn[BIT_DIVZERO]) begin
      reported[BIT_DIVZERO] = 1'b1;
      majorUnmasked    = unmasked[BIT_DIVZERO];
      strobe.resultSel = SEL_DEFAULT;
    end else if (condIn[BIT_OVERFLOW] || condIn[BIT_UNDERFL]) begin
      ovunTrap = (condIn[BIT_OVERFLOW] && unmasked[BIT_OVERFLOW]) ||
                 (condIn[BIT_UNDERFL]  && unmasked[BIT_UNDERFL]);
      hideInexact = ovunTrap && destIsMem;
      reported[BIT_OVERFLOW] = condIn[BIT_OVERFLOW];
      reported[BIT_UNDERFL]  = condIn[BIT_UNDERFL];
      reported[BIT_INEXACT]  = condIn[BIT_INEXACT] && !hideInexact;
      majorUnmasked    = ovunTrap;
      strobe.resultSel = SEL_DEFAULT;
    end else begin
      reported[BIT_INEXACT] = condIn[BIT_INEXACT];
    end

    if (majorUnmasked && destIsMem) strobe.resultSel = SEL_NOSTORE;

    trapSet          = reported & unmasked;
    strobe.setFlags  = reported;
    strobe.trapReq   = |trapSet;
    strobe.trapCause = trapSet & (~trapSet + 1'b1);
    strobe.c1Clear   = hideInexact;
    strobe.c1Load    = reported[BIT_INEXACT];
    strobe.c1Value   = roundUp;
  end

  // R7: invalid present never lets a lower-ranked flag through
  a_r7_invalid_first: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && condIn[BIT_INVALID]) |->
      (strobe.setFlags == 5'b00001) &&
      (strobe.resultSel == SEL_QNAN || strobe.resultSel == SEL_NOSTORE));

  // R6: unmasked over/underflow to memory hides inexact and the store
  a_r6_mem_suppress: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !condIn[BIT_INVALID] && !condIn[BIT_DIVZERO] && destIsMem &&
     ((condIn[BIT_OVERFLOW] && !maskIn[BIT_OVERFLOW]) ||
      (condIn[BIT_UNDERFL]  && !maskIn[BIT_UNDERFL]))) |->
      (!strobe.setFlags[BIT_INEXACT] && strobe.c1Clear &&
       strobe.resultSel == SEL_NOSTORE));

  // R3: an inexact-only operation always keeps the rounded result
  a_r3_rounded_kept: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && condIn == 5'b10000) |-> (strobe.resultSel == SEL_ROUNDED));
endmodule

// File: rtl/fpx_state.sv
module fpx_state
  import fpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic                 clearFlags,
  input  fpxStrobe_t           strobe,
  output logic [EXC_COUNT-1:0] stickyFlags,
  output logic                 c1Bit,
  output logic                 trapReq,
  output logic [EXC_COUNT-1:0] trapCause,
  output logic [SEL_WIDTH-1:0] resultSel
);
  for (genvar i = 0; i < EXC_COUNT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN || clearFlags) stickyFlags[i] <= 1'b0;
      else if (opValid && strobe.setFlags[i]) stickyFlags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearFlags) c1Bit <= 1'b0;
    else if (opValid) begin
      if (strobe.c1Clear) c1Bit <= 1'b0;
      else if (strobe.c1Load) c1Bit <= strobe.c1Value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapReq   <= 1'b0;
      trapCause <= '0;
      resultSel <= SEL_ROUNDED;
    end else if (opValid) begin
      trapReq   <= strobe.trapReq;
      trapCause <= strobe.trapCause;
      resultSel <= strobe.resultSel;
    end
  end

  // R10: flags only accumulate while no clear arrives
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    !clearFlags |=> ((stickyFlags & $past(stickyFlags)) == $past(stickyFlags)));

  // R10: clear wins over a same-cycle set
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags |=> (stickyFlags == '0 && !c1Bit));

  // R11: idle cycles freeze every output
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !clearFlags) |=> ($stable(stickyFlags) && $stable(c1Bit) &&
      $stable(trapReq) && $stable(trapCause) && $stable(resultSel)));

  // R9: cause is one-hot and agrees with the request
  a_r9_cause_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trapCause) && (trapReq == (trapCause != '0)));
endmodule

// File: rtl/fpx_resolver.sv
module fpx_resolver
  import fpx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       clearFlags,
  input  logic [4:0] condIn,
  input  logic [4:0] maskIn,
  input  logic       destIsMem,
  input  logic       roundUp,
  output logic [4:0] stickyFlags,
  output logic       c1Bit,
  output logic       trapReq,
  output logic [4:0] trapCause,
  output logic [1:0] resultSel
);
  fpxStrobe_t strobe;

  fpx_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .condIn    (condIn),
    .maskIn    (maskIn),
    .destIsMem (destIsMem),
    .roundUp   (roundUp),
    .strobe    (strobe)
  );

  fpx_state u_state (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .clearFlags  (clearFlags),
    .strobe      (strobe),
    .stickyFlags (stickyFlags),
    .c1Bit       (c1Bit),
    .trapReq     (trapReq),
    .trapCause   (trapCause),
    .resultSel   (resultSel)
  );
endmodule

// File: tb/tb_fpx_resolver.sv
`timescale 1ns/1ps
module tb_fpx_resolver;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic clearFlags = 1'b0;
  logic [4:0] condIn = '0;
  logic [4:0] maskIn = '1;
  logic destIsMem = 1'b0;
  logic roundUp = 1'b0;
  logic [4:0] stickyFlags;
  logic c1Bit;
  logic trapReq;
  logic [4:0] trapCause;
  logic [1:0] resultSel;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fpx_resolver dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .clearFlags(clearFlags),
    .condIn(condIn), .maskIn(maskIn), .destIsMem(destIsMem), .roundUp(roundUp),
    .stickyFlags(stickyFlags), .c1Bit(c1Bit), .trapReq(trapReq),
    .trapCause(trapCause), .resultSel(resultSel)
  );

  // {cond, mask, mem, roundUp, expFlags, expC1, expTrap, expCause, expSel}
  localparam int NVEC = 15;
  localparam logic [25:0] VEC [NVEC] = '{
    26'b10000_11111_0_1_10000_1_0_00000_00, // R2
    26'b10000_01111_0_0_10000_0_1_10000_00, // R3
    26'b10000_01111_1_1_10000_1_1_10000_00, // R13
    26'b10100_11111_0_1_10100_1_0_00000_01, // R4
    26'b11000_01111_0_0_11000_0_1_10000_01, // R4
    26'b10100_11011_0_1_10100_1_1_00100_01, // R5
    26'b11000_10111_1_1_01000_0_1_01000_11, // R6
    26'b00011_11111_0_0_00001_0_0_00000_10, // R7
    26'b00011_11101_0_0_00001_0_0_00000_10, // R7
    26'b10001_11110_1_1_00001_0_1_00001_11, // R13
    26'b10010_11111_0_1_00010_0_0_00000_01, // R8
    26'b00010_11101_0_0_00010_0_1_00010_01, // R9
    26'b00000_00000_0_1_00000_0_0_00000_00, // R2
    26'b10100_01111_1_1_10100_1_1_10000_01, // R4
    26'b00100_11011_1_0_00100_0_1_00100_11  // R13
  };

  function automatic string reqOf(int idx);
    case (idx)
      0, 12:   return "R2";
      1:       return "R3";
      2, 9, 14: return "R13";
      3, 4, 13: return "R4";
      5:       return "R5";
      6:       return "R6";
      7, 8:    return "R7";
      10:      return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [13:0] outs();
    return {stickyFlags, c1Bit, trapReq, trapCause, resultSel};
  endfunction

  task automatic checkEq(string req, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic doOp(logic [4:0] c, logic [4:0] m, logic mem, logic ru);
    @(negedge clk);
    condIn = c; maskIn = m; destIsMem = mem; roundUp = ru; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk);
    clearFlags = 1'b1;
    @(negedge clk);
    clearFlags = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1", outs(), 14'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", outs(), 14'b0);

    for (int i = 0; i < NVEC; i++) begin
      doClear();
      doOp(VEC[i][25:21], VEC[i][20:16], VEC[i][15], VEC[i][14]);
      checkEq(reqOf(i), outs(), VEC[i][13:0]);
    end

    // R10: flags accumulate across operations
    doClear();
    doOp(5'b00010, 5'b11111, 1'b0, 1'b0);
    doOp(5'b10000, 5'b11111, 1'b0, 1'b1);
    checkEq("R10", outs(), 14'b10010_1_0_00000_00);

    // R11: idle cycles with changing inputs leave everything alone
    @(negedge clk);
    condIn = 5'b00001; maskIn = 5'b00000; destIsMem = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R11", outs(), 14'b10010_1_0_00000_00);

    // R12: an op without inexact leaves C1 set
    doOp(5'b00100, 5'b11111, 1'b0, 1'b0);
    checkEq("R12", outs(), 14'b10110_1_0_00000_01);

    // R6: the memory overflow case clears a set C1 and keeps flag 4 as it was
    doClear();
    doOp(5'b10000, 5'b11111, 1'b0, 1'b1);
    doClear();
    doOp(5'b01000, 5'b11111, 1'b0, 1'b0);
    doOp(5'b10000, 5'b11111, 1'b0, 1'b1);
    checkEq("R12", outs(), 14'b11000_1_0_00000_00);
    doOp(5'b10100, 5'b11011, 1'b1, 1'b1);
    checkEq("R6", outs(), 14'b11100_0_1_00100_11);

    // R10: clear in the same cycle as a set
    @(negedge clk);
    condIn = 5'b10001; maskIn = 5'b11111; destIsMem = 1'b0; roundUp = 1'b1;
    opValid = 1'b1; clearFlags = 1'b1;
    @(negedge clk);
    opValid = 1'b0; clearFlags = 1'b0;
    checkEq("R10", outs(), 14'b00000_0_0_00000_10);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule